// File: doc/BRIEF.md
# Cache Request Front End with Full-Line Write Allocation

This block sits at the processor side of a single-level cache controller. It accepts one request at a time and classifies it. Each request carries a command, an address, a byte size, an uncacheable flag and a locked flag. For a cacheable request the block drives a tag-lookup port with the block-aligned address. In the same cycle it asks an outstanding-miss table whether a miss to that block is already in flight. From these answers it decides on one of three outcomes: a hit, a fill that installs the line without fetching it, or a miss handed to the miss queue.

When a lookup or a fill evicts a victim line, the victim's address is pushed out on a writeback port with a valid/ready handshake. Every such writeback is sent before the hit or miss outcome is reported. Hit responses come out a fixed number of cycles after the outcome. Misses carry a ready time stamped from a free-running cycle counter. The block also counts cacheable misses against a limit and raises a sticky stop flag when the limit runs out. Locked stores are reported as successful.

Tag storage, the data arrays, the coherence protocol and the memory side are outside the block. They appear only as simple ports.

Top module: `cache_front`

## Requirements
- R1: A request with the uncacheable flag set never raises `lk_valid`, so any victim offered on the lookup port is ignored. Its miss carries the request's own unaligned address and its own size, and it does not count toward the miss limit.
- R2: Fast allocation happens on a cacheable lookup miss when all of the following hold:
  - the command is write (1) or write-invalidate (2);
  - `req_size` is at least one block;
  - `cfg_fast_ok` is 1.
  In that case `fill_valid` pulses with the block address, the request completes as a hit and no miss is issued. If any one condition fails, the request is a miss.
- R3: A plain write (1) takes the fast path only when `mt_match` is 0. A write-invalidate (2) takes it even when `mt_match` is 1, and in that case `winv_clash` pulses in the outcome cycle.
- R4: Victims are sent in this order: first the lookup victim, then the fill victim. All of them are sent before the outcome cycle. While `wb_ready` is low, `wb_valid` stays high and `wb_addr` holds steady.
- R5: A hit with command read (0), write (1) or write-invalidate (2) produces exactly one `rsp_valid` pulse, carrying the request address, HIT_LAT cycles after the outcome cycle. A hit with writeback (3) produces no response.
- R6: A writeback command (3) that hits pulses `wb_retire` in the outcome cycle.
- R7: Each cacheable miss lowers a counter that starts at MISS_LIMIT. `halt` rises after the miss that brings the counter to zero and stays high. A MISS_LIMIT of 0 disables the counter.
- R8: A cacheable miss pulses `miss_valid` for one cycle, with these fields:
  - `miss_addr`: the block-aligned address;
  - `miss_size`: BLK_BYTES;
  - `miss_due`: the cycle count since reset plus HIT_LAT.
  The outcome cycle follows the lookup cycle directly when there are no victims.
- R9: A locked write (command 1) pulses `sc_pass`, meaning a success result of 1, in its outcome cycle. A locked read does not.
- R10: After reset, `req_ready` is 1 and the following outputs are 0: `wb_valid`, `miss_valid`, `rsp_valid`, `fill_valid`, `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_cmd | input | 2 | 0 read, 1 write, 2 write-invalidate, 3 writeback |
| req_addr | input | AW | Byte address |
| req_size | input | log2(BLK_BYTES)+1 | Request size in bytes |
| req_unc | input | 1 | Uncacheable request |
| req_lock | input | 1 | Locked (store-conditional) request |
| cfg_fast_ok | input | 1 | Protocol permits allocation without fetch |
| lk_valid | output | 1 | Tag lookup strobe |
| lk_addr | output | AW | Block address looked up |
| lk_hit | input | 1 | Lookup hit |
| lk_vic_valid | input | 1 | Lookup produced a victim |
| lk_vic_addr | input | AW | Lookup victim address |
| fill_valid | output | 1 | Install line valid and writable |
| fill_addr | output | AW | Block address installed |
| fill_vic_valid | input | 1 | Fill produced a victim |
| fill_vic_addr | input | AW | Fill victim address |
| mt_addr | output | AW | Block address queried in the miss table |
| mt_match | input | 1 | Outstanding miss to that block |
| wb_valid | output | 1 | Victim writeback present |
| wb_addr | output | AW | Victim address |
| wb_ready | input | 1 | Writeback queue accepts |
| rsp_valid | output | 1 | Hit response |
| rsp_addr | output | AW | Address of responded request |
| miss_valid | output | 1 | Miss issued |
| miss_addr | output | AW | Miss address |
| miss_size | output | log2(BLK_BYTES)+1 | Miss size in bytes |
| miss_due | output | TW | Miss ready time |
| wb_retire | output | 1 | Writeback command satisfied |
| sc_pass | output | 1 | Locked write succeeded |
| winv_clash | output | 1 | Write-invalidate allocated over outstanding miss |
| halt | output | 1 | Miss limit reached |

## Verification
The bench builds the block with these parameters: a 16-byte block, a 16-bit address, HIT_LAT of 3 and MISS_LIMIT of 3. The small block makes full-line and partial writes easy to tell apart with small size values. A three-cycle latency keeps the response clearly separate from the outcome cycle, so an off-by-one shift shows up. A limit of three lets a short directed sequence mix cacheable and uncacheable misses and still reach the stop flag.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_WINV  = 2'd2,
    CMD_WBACK = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } st_e;
endpackage

// File: rtl/cfe_decide.sv
module cfe_decide #(
  parameter int BLK_BYTES = 64,
  parameter int SW        = 7
) (
  input  logic [1:0]    cmd,
  input  logic [SW-1:0] size,
  input  logic          unc,
  input  logic          lk_hit,
  input  logic          mt_match,
  input  logic          fast_ok,
  output logic          hit,
  output logic          fast,
  output logic          clash
);
  import cfe_pkg::*;
  localparam logic [SW-1:0] BLK_SZ = SW'(BLK_BYTES);

  logic full_line;
  logic is_wr;
  logic is_winv;

  always_comb begin
    full_line = (size >= BLK_SZ);
    is_wr     = (cmd == CMD_WRITE);
    is_winv   = (cmd == CMD_WINV);
    hit       = !unc && lk_hit;
    fast      = !unc && !lk_hit && full_line && fast_ok &&
                ((is_wr && !mt_match) || is_winv);
    clash     = fast && is_winv && mt_match;
  end
endmodule

// File: rtl/cfe_vicq.sv
module cfe_vicq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          a_v,
  input  logic [AW-1:0] a_addr,
  input  logic          b_v,
  input  logic [AW-1:0] b_addr,
  input  logic          pop,
  output logic          head_v,
  output logic [AW-1:0] head_addr,
  output logic          last
);
  logic [AW-1:0] e0_q, e1_q, e0_n, e1_n;
  logic [1:0]    cnt_q, cnt_n;

  always_comb begin
    e0_n  = e0_q;
    e1_n  = e1_q;
    cnt_n = cnt_q;
    if (load) begin
      if (a_v) begin
        e0_n = a_addr;
        e1_n = b_addr;
      end else begin
        e0_n = b_addr;
      end
      cnt_n = {1'b0, a_v} + {1'b0, b_v};
    end else if (pop) begin
      e0_n  = e1_q;
      cnt_n = cnt_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0_q  <= '0;
      e1_q  <= '0;
      cnt_q <= '0;
    end else if (load || pop) begin
      e0_q  <= e0_n;
      e1_q  <= e1_n;
      cnt_q <= cnt_n;
    end
  end

  assign head_v    = (cnt_q != 2'd0);
  assign head_addr = e0_q;
  assign last      = (cnt_q == 2'd1);

  a_r4_load_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == 2'd0));
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != 2'd0));
endmodule

// File: rtl/cfe_rsp_pipe.sv
module cfe_rsp_pipe #(
  parameter int AW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [AW-1:0] in_addr,
  output logic          out_v,
  output logic [AW-1:0] out_addr
);
  for (genvar g = 0; g < DEPTH; g++) begin : stg
    logic          v_q;
    logic [AW-1:0] a_q;
    logic          src_v;
    logic [AW-1:0] src_a;
    if (g == 0) begin : g_head
      assign src_v = in_v;
      assign src_a = in_addr;
    end else begin : g_tail
      assign src_v = stg[g-1].v_q;
      assign src_a = stg[g-1].a_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        a_q <= '0;
      end else begin
        v_q <= src_v;
        if (src_v) a_q <= src_a;
      end
    end
  end

  assign out_v    = stg[DEPTH-1].v_q;
  assign out_addr = stg[DEPTH-1].a_q;
endmodule

// File: rtl/cfe_miss_limit.sv
module cfe_miss_limit #(
  parameter int LIMIT = 0,
  parameter int CW    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec,
  output logic halt
);
  localparam bit ENABLED = (LIMIT != 0);

  logic [CW-1:0] left_q, left_n;
  logic          halt_q, halt_n;

  always_comb begin
    left_n = left_q;
    halt_n = halt_q;
    if (ENABLED && dec && (left_q != '0)) begin
      left_n = left_q - CW'(1);
      if (left_q == CW'(1)) halt_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= CW'(LIMIT);
      halt_q <= 1'b0;
    end else if (dec) begin
      left_q <= left_n;
      halt_q <= halt_n;
    end
  end

  assign halt = halt_q;

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  a_r7_halt_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(dec));
endmodule

// File: rtl/cache_front.sv
module cache_front #(
  parameter int AW         = 32,
  parameter int BLK_BYTES  = 64,
  parameter int HIT_LAT    = 2,
  parameter int MISS_LIMIT = 0,
  parameter int TW         = 32,
  localparam int OFS = $clog2(BLK_BYTES),
  localparam int SW  = OFS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size,
  input  logic          req_unc,
  input  logic          req_lock,
  input  logic          cfg_fast_ok,
  output logic          lk_valid,
  output logic [AW-1:0] lk_addr,
  input  logic          lk_hit,
  input  logic          lk_vic_valid,
  input  logic [AW-1:0] lk_vic_addr,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_vic_valid,
  input  logic [AW-1:0] fill_vic_addr,
  output logic [AW-1:0] mt_addr,
  input  logic          mt_match,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  input  logic          wb_ready,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          miss_valid,
  output logic [AW-1:0] miss_addr,
  output logic [SW-1:0] miss_size,
  output logic [TW-1:0] miss_due,
  output logic          wb_retire,
  output logic          sc_pass,
  output logic          winv_clash,
  output logic          halt
);
  import cfe_pkg::*;

  localparam int            LCW    = $clog2(MISS_LIMIT + 2);
  localparam logic [SW-1:0] BLK_SZ = SW'(BLK_BYTES);

  st_e           st_q, st_n;
  logic [1:0]    cmd_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q;
  logic          unc_q, lock_q;
  logic          hit_q, clash_q;
  logic [TW-1:0] now_q;

  logic [AW-1:0] blk_addr;
  logic          d_hit, d_fast, d_clash;
  logic          accept, in_look, in_done;
  logic          vic_a, vic_b, q_head, q_last, pop;
  logic          rsp_in, miss_dec;

  assign accept   = (st_q == ST_IDLE) && req_valid;
  assign in_look  = (st_q == ST_LOOK);
  assign in_done  = (st_q == ST_DONE);
  assign blk_addr = {addr_q[AW-1:OFS], {OFS{1'b0}}};

  cfe_decide #(.BLK_BYTES(BLK_BYTES), .SW(SW)) u_dec (
    .cmd(cmd_q), .size(size_q), .unc(unc_q), .lk_hit(lk_hit),
    .mt_match(mt_match), .fast_ok(cfg_fast_ok),
    .hit(d_hit), .fast(d_fast), .clash(d_clash));

  // Lookup, miss-table query and fill all happen in the lookup cycle
  assign lk_valid   = in_look && !unc_q;
  assign lk_addr    = blk_addr;
  assign mt_addr    = blk_addr;
  assign fill_valid = in_look && d_fast;
  assign fill_addr  = blk_addr;

  assign vic_a = lk_valid && lk_vic_valid;
  assign vic_b = fill_valid && fill_vic_valid;
  assign pop   = wb_valid && wb_ready;

  cfe_vicq #(.AW(AW)) u_vq (
    .clk(clk), .rst_n(rst_n), .load(in_look),
    .a_v(vic_a), .a_addr(lk_vic_addr),
    .b_v(vic_b), .b_addr(fill_vic_addr),
    .pop(pop), .head_v(q_head), .head_addr(wb_addr), .last(q_last));

  assign wb_valid = (st_q == ST_DRAIN) && q_head;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_n = ST_LOOK;
      ST_LOOK:  st_n = (vic_a || vic_b) ? ST_DRAIN : ST_DONE;
      ST_DRAIN: if (pop && q_last) st_n = ST_DONE;
      ST_DONE:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      now_q <= '0;
    end else begin
      st_q  <= st_n;
      now_q <= now_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      size_q <= '0;
      unc_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (accept) begin
      cmd_q  <= req_cmd;
      addr_q <= req_addr;
      size_q <= req_size;
      unc_q  <= req_unc;
      lock_q <= req_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      clash_q <= 1'b0;
    end else if (in_look) begin
      hit_q   <= d_hit || d_fast;
      clash_q <= d_clash;
    end
  end

  // Outcome cycle
  assign req_ready  = (st_q == ST_IDLE);
  assign miss_valid = in_done && !hit_q;
  assign miss_addr  = unc_q ? addr_q : blk_addr;
  assign miss_size  = unc_q ? size_q : BLK_SZ;
  assign miss_due   = now_q + TW'(HIT_LAT);
  assign rsp_in     = in_done && hit_q && (cmd_q != CMD_WBACK);
  assign wb_retire  = in_done && hit_q && (cmd_q == CMD_WBACK);
  assign sc_pass    = in_done && lock_q && (cmd_q == CMD_WRITE);
  assign winv_clash = in_done && clash_q;
  assign miss_dec   = miss_valid && !unc_q;

  cfe_rsp_pipe #(.AW(AW), .DEPTH(HIT_LAT)) u_rsp (
    .clk(clk), .rst_n(rst_n), .in_v(rsp_in), .in_addr(addr_q),
    .out_v(rsp_valid), .out_addr(rsp_addr));

  cfe_miss_limit #(.LIMIT(MISS_LIMIT), .CW(LCW)) u_lim (
    .clk(clk), .rst_n(rst_n), .dec(miss_dec), .halt(halt));

  a_r4_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));
  a_r8_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (!miss_valid && req_ready));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!wb_valid && !miss_valid && !fill_valid));
  a_r2_fill_outcome_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (wb_valid || !miss_valid));
endmodule

// File: tb/sim_cache_front.sv
module sim_cache_front;
  localparam int CLK_PER = 10;
  localparam int AW = 16, BLK = 16, HL = 3, LIM = 3, TW = 32;
  localparam int SW = $clog2(BLK) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic          req_unc = 1'b0, req_lock = 1'b0;
  logic          e_fast = 1'b1, e_hit = 1'b0, e_lkv = 1'b0, e_flv = 1'b0, e_mt = 1'b0;
  logic [AW-1:0] e_lka = '0, e_fla = '0;
  logic          lk_valid, fill_valid, wb_valid, rsp_valid, miss_valid;
  logic [AW-1:0] lk_addr, fill_addr, mt_addr, wb_addr, rsp_addr, miss_addr;
  logic [SW-1:0] miss_size;
  logic [TW-1:0] miss_due;
  logic          wb_ready = 1'b1;
  logic          wb_retire, sc_pass, winv_clash, halt;

  cache_front #(.AW(AW), .BLK_BYTES(BLK), .HIT_LAT(HL), .MISS_LIMIT(LIM), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_size(req_size),
    .req_unc(req_unc), .req_lock(req_lock), .cfg_fast_ok(e_fast),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(e_hit),
    .lk_vic_valid(e_lkv), .lk_vic_addr(e_lka),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_vic_valid(e_flv), .fill_vic_addr(e_fla),
    .mt_addr(mt_addr), .mt_match(e_mt),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_size(miss_size),
    .miss_due(miss_due), .wb_retire(wb_retire), .sc_pass(sc_pass),
    .winv_clash(winv_clash), .halt(halt));

  int total = 0, bad = 0, cmiss = 0;
  logic [TW-1:0] tcnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0; else tcnt <= tcnt + 1;

  // results of one request
  int n_miss, miss_cyc, n_rsp, rsp_cyc, n_lk, n_fill, n_wb, n_ret, ret_cyc, n_sc, n_clash;
  logic [AW-1:0] m_addr, r_addr, f_addr, wb0, wb1, lk_a;
  logic [SW-1:0] m_size;
  logic [TW-1:0] m_due, m_exp_due;
  bit hold_ok;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [AW-1:0] a, input logic [SW-1:0] s,
                       input logic u, input logic l, input int stall);
    int stl = stall;
    logic [AW-1:0] prev_wb = '0;
    bit stalled = 0;
    n_miss = 0; miss_cyc = -1; n_rsp = 0; rsp_cyc = -1; n_lk = 0; n_fill = 0;
    n_wb = 0; n_ret = 0; ret_cyc = -1; n_sc = 0; n_clash = 0; hold_ok = 1;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_size = s; req_unc = u; req_lock = l; req_valid = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (lk_valid) begin n_lk++; lk_a = lk_addr; end
      if (fill_valid) begin n_fill++; f_addr = fill_addr; end
      if (miss_valid) begin
        n_miss++; miss_cyc = i; m_addr = miss_addr; m_size = miss_size;
        m_due = miss_due; m_exp_due = tcnt + TW'(HL);
      end
      if (rsp_valid) begin n_rsp++; rsp_cyc = i; r_addr = rsp_addr; end
      if (wb_retire) begin n_ret++; ret_cyc = i; end
      if (sc_pass) n_sc++;
      if (winv_clash) n_clash++;
      if (stalled && (!wb_valid || wb_addr != prev_wb)) hold_ok = 0;
      stalled = 0;
      if (wb_valid) begin
        if (stl > 0) begin
          wb_ready = 1'b0; stl--; stalled = 1; prev_wb = wb_addr;
        end else begin
          wb_ready = 1'b1;
          if (n_wb == 0) wb0 = wb_addr; else wb1 = wb_addr;
          n_wb++;
        end
      end else wb_ready = 1'b1;
    end
    wb_ready = 1'b1;
  endtask

  task automatic env(input logic hit, input logic mt, input logic fast,
                     input logic lkv, input logic flv);
    e_hit = hit; e_mt = mt; e_fast = fast; e_lkv = lkv; e_flv = flv;
    e_lka = 16'hA000; e_fla = 16'hB000;
  endtask

  task automatic check_halt();
    chk(halt == (cmiss >= LIM), "R7 halt state", halt, cmiss >= LIM);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
    chk({wb_valid, miss_valid, rsp_valid, fill_valid, halt} == 5'b0, "R10 outputs quiet",
        {wb_valid, miss_valid, rsp_valid, fill_valid, halt}, 0);
  endtask

  task automatic t_read_hit();
    env(1, 0, 1, 0, 0);
    issue(2'd0, 16'h1234, 5'd4, 0, 0, 0);
    chk(n_lk == 1 && lk_a == 16'h1230, "R5 lookup block addr", lk_a, 16'h1230);
    chk(n_rsp == 1 && rsp_cyc == 1 + HL, "R5 read hit rsp cycle", rsp_cyc, 1 + HL);
    chk(r_addr == 16'h1234, "R5 rsp addr", r_addr, 16'h1234);
    chk(n_miss == 0, "R5 no miss on hit", n_miss, 0);
  endtask

  task automatic t_wback_hit();
    env(1, 0, 1, 0, 0);
    issue(2'd3, 16'h2200, 5'd16, 0, 0, 0);
    chk(n_rsp == 0, "R5 writeback hit no response", n_rsp, 0);
    chk(n_ret == 1 && ret_cyc == 1, "R6 retire pulse", ret_cyc, 1);
  endtask

  task automatic t_read_miss();
    env(0, 0, 1, 0, 0);
    issue(2'd0, 16'h3456, 5'd4, 0, 0, 0);
    cmiss++;
    chk(n_miss == 1 && miss_cyc == 1, "R8 miss cycle", miss_cyc, 1);
    chk(m_addr == 16'h3450, "R8 miss block addr", m_addr, 16'h3450);
    chk(m_size == 5'd16, "R8 miss size", m_size, 16);
    chk(m_due == m_exp_due, "R8 miss due time", m_due, m_exp_due);
    check_halt();
  endtask

  task automatic t_uncached();
    env(1, 0, 1, 1, 0);
    issue(2'd0, 16'h4567, 5'd2, 1, 0, 0);
    chk(n_lk == 0, "R1 no lookup", n_lk, 0);
    chk(n_wb == 0, "R1 lookup victim ignored", n_wb, 0);
    chk(n_miss == 1 && m_addr == 16'h4567, "R1 unaligned miss addr", m_addr, 16'h4567);
    chk(m_size == 5'd2, "R1 own size", m_size, 2);
    check_halt();
  endtask

  task automatic t_fast_write();
    env(0, 0, 1, 0, 0);
    issue(2'd1, 16'h5008, 5'd16, 0, 0, 0);
    chk(n_fill == 1 && f_addr == 16'h5000, "R2 fill block addr", f_addr, 16'h5000);
    chk(n_miss == 0, "R2 no miss", n_miss, 0);
    chk(n_rsp == 1 && rsp_cyc == 1 + HL, "R2 rsp as hit", rsp_cyc, 1 + HL);
  endtask

  task automatic t_fast_off();
    env(0, 0, 0, 0, 0);
    issue(2'd1, 16'h6000, 5'd16, 0, 0, 0);
    cmiss++;
    chk(n_fill == 0 && n_miss == 1, "R2 protocol forbids fast", n_fill, 0);
    env(0, 0, 1, 0, 0);
    issue(2'd1, 16'h6100, 5'd8, 0, 0, 0);
    cmiss++;
    chk(n_fill == 0 && n_miss == 1, "R2 partial write misses", n_fill, 0);
    check_halt();
  endtask

  task automatic t_outstanding();
    env(0, 1, 1, 0, 0);
    issue(2'd1, 16'h7000, 5'd16, 0, 0, 0);
    cmiss++;
    chk(n_fill == 0 && n_miss == 1 && n_clash == 0, "R3 plain write blocked", n_fill, 0);
    check_halt();
    issue(2'd2, 16'h7100, 5'd16, 0, 0, 0);
    chk(n_fill == 1 && n_miss == 0, "R3 winv allocates", n_fill, 1);
    chk(n_clash == 1, "R3 clash flag", n_clash, 1);
    chk(n_rsp == 1, "R3 winv rsp", n_rsp, 1);
  endtask

  task automatic t_victims();
    env(0, 0, 1, 1, 0);
    issue(2'd0, 16'h8000, 5'd4, 0, 0, 0);
    cmiss++;
    chk(n_wb == 1 && wb0 == 16'hA000, "R4 lookup victim", wb0, 16'hA000);
    chk(miss_cyc == 2, "R4 miss after drain", miss_cyc, 2);
    env(0, 0, 1, 1, 1);
    issue(2'd1, 16'h8100, 5'd16, 0, 0, 2);
    chk(n_wb == 2 && wb0 == 16'hA000 && wb1 == 16'hB000, "R4 order", {wb0, wb1}, 32'hA000B000);
    chk(hold_ok, "R4 hold while stalled", hold_ok, 1);
    chk(rsp_cyc == 1 + 2 + 2 + HL, "R4 outcome after drain", rsp_cyc, 1 + 2 + 2 + HL);
    check_halt();
  endtask

  task automatic t_locked();
    env(1, 0, 1, 0, 0);
    issue(2'd1, 16'h9000, 5'd4, 0, 1, 0);
    chk(n_sc == 1, "R9 locked write success", n_sc, 1);
    issue(2'd0, 16'h9000, 5'd4, 0, 1, 0);
    chk(n_sc == 0, "R9 locked read silent", n_sc, 0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_wback_hit();
    t_read_miss();
    t_uncached();
    t_fast_write();
    t_fast_off();
    t_outstanding();
    t_victims();
    t_locked();
    check_halt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule